// File: doc/BRIEF.md
# Interrupt context stacking sequencer

This block saves and restores a CPU's register context through a byte-wide memory port. When an interrupt is accepted, the core pulses the push strobe. The sequencer then writes nine bytes onto a stack that grows downward, one byte per cycle: the program counter, the two index registers, the two accumulators and the condition code register (CCR). It then reports the new stack pointer and the live CCR with the mask bits set for interrupt service. When the core returns from an interrupt, it pulses the pop strobe. The sequencer reads the same nine bytes back in the reverse order and presents the restored registers and stack pointer.

Entry through the non-maskable external interrupt raises both mask bits. Entry through any other source raises only the interrupt mask. On return, both masks come from the stacked CCR, with one exception: a cleared non-maskable mask is never set again by a return. The block does not fetch vectors or do arithmetic for the core.

Top module: `ctxStacker`

## Requirements
- R1: While reset is held and after it is released, memWe, memRe and done are low, and spOut and every restored-register output read zero.
- R2: A push strobe sampled while idle starts 9 write cycles in a row, in the cycle after the strobe. Write k (k = 0..8) goes to address spIn−k. The bytes, in order, are: PC low, PC high, IY low, IY high, IX low, IX high, accumulator A, accumulator B, CCR.
- R3: The CCR byte is the ninth and last write. It holds ccrIn exactly as sampled with the strobe, before any mask bit is changed.
- R4: One cycle after the last write, done is high, and spOut equals the sampled spIn minus 9. pcOut, iyOut, ixOut, accAOut and accBOut equal the sampled inputs. ccrOut is the sampled CCR with the I mask (bit 4) set. When xirqEntry was high, the X mask (bit 6) is also set; otherwise bit 6 is unchanged.
- R5: A pop strobe sampled while idle starts 9 read cycles in a row, in the cycle after the strobe, at addresses spIn+1 through spIn+9. The bytes read are taken as CCR, B, A, IX high, IX low, IY high, IY low, PC high, PC low. memRdata is sampled in the same cycle as its address.
- R6: One cycle after the last read, done is high, and spOut equals the sampled spIn plus 9. The register outputs hold the bytes read. ccrOut carries the stacked I mask and the other stacked bits.
- R7: On return, the restored X bit is the stacked X bit ANDed with bit 6 of the ccrIn sampled at the pop strobe, so a return never sets a cleared X mask.
- R8: A push or pop strobe that arrives during a sequence or during its done cycle is ignored. The sequence keeps its addresses and data, and no further memory cycle follows it.
- R9: When push and pop strobes arrive together while idle, only the push is performed.
- R10: done is high for exactly one cycle per sequence, and a sequence lasts 10 cycles from strobe to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPush | input | 1 | Begin saving context (interrupt accepted) |
| startPop | input | 1 | Begin restoring context (return from interrupt) |
| xirqEntry | input | 1 | The accepted interrupt is the non-maskable external one |
| pcIn | input | 16 | Program counter to save |
| iyIn | input | 16 | IY index register to save |
| ixIn | input | 16 | IX index register to save |
| accAIn | input | 8 | Accumulator A to save |
| accBIn | input | 8 | Accumulator B to save |
| ccrIn | input | 8 | Live CCR (S,X,H,I,N,Z,V,C from bit 7 down) |
| spIn | input | AW | Current stack pointer |
| memRdata | input | 8 | Memory read data, valid in the read cycle |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memAddr | output | AW | Memory byte address |
| memWdata | output | 8 | Memory write data |
| spOut | output | AW | Stack pointer after the sequence |
| pcOut | output | 16 | Restored or saved program counter |
| iyOut | output | 16 | Restored or saved IY |
| ixOut | output | 16 | Restored or saved IX |
| accAOut | output | 8 | Restored or saved accumulator A |
| accBOut | output | 8 | Restored or saved accumulator B |
| ccrOut | output | 8 | Live CCR after the sequence |
| done | output | 1 | One-cycle completion pulse |

## Verification
Pushes use register values with a distinct byte in every position. A swap of high and low halves, of the two index registers or of the accumulators therefore shows up as a wrong byte at a known address. Entry with the CCR masks clear is run through both the maskable and the non-maskable path, which separates a stored CCR that was changed too early from a live CCR update that lacks the X bit. Returns are run with the stacked X and the live X in each relevant combination, including a stacked byte altered to claim X set, so that a full restore is told apart from the X rule. Stray strobes in the middle of a sequence, in its done cycle and at the same time as each other check that no extra or reordered memory cycle appears.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int CTX_BYTES = 9;
  localparam int IDX_W = $clog2(CTX_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CTX_BYTES - 1);
  localparam int CCR_X = 6;
  localparam int CCR_I = 4;

  typedef struct packed {
    logic capture;
    logic popDir;
    logic doWrite;
    logic doRead;
    logic finish;
    logic [IDX_W-1:0] idx;
  } ctlBus_t;
endpackage

// File: rtl/ctxCtl.sv
module ctxCtl
  import ctx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPush,
  input  logic    startPop,
  output ctlBus_t ctl,
  output logic    done
);
  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP, S_DONE} state_t;
  state_t state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          idx <= '0;
          if (startPush) state <= S_PUSH;
          else if (startPop) state <= S_POP;
        end
        S_PUSH, S_POP: begin
          if (idx == LAST_IDX) state <= S_DONE;
          else idx <= idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture = (state == S_IDLE) && (startPush || startPop);
    ctl.popDir  = (state == S_IDLE) ? (!startPush && startPop) : (state == S_POP);
    ctl.doWrite = (state == S_PUSH);
    ctl.doRead  = (state == S_POP);
    ctl.finish  = (ctl.doWrite || ctl.doRead) && (idx == LAST_IDX);
    ctl.idx     = idx;
    done        = (state == S_DONE);
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R10
  finish_done_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.finish |=> done);
  // R8
  push_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doWrite && !ctl.finish) |=> (ctl.doWrite && ctl.idx == $past(ctl.idx) + 1'b1));
  // R8
  pop_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doRead && !ctl.finish) |=> (ctl.doRead && ctl.idx == $past(ctl.idx) + 1'b1));
endmodule

// File: rtl/ctxData.sv
module ctxData
  import ctx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlBus_t       ctl,
  input  logic          xirqEntry,
  input  logic [15:0]   pcIn,
  input  logic [15:0]   iyIn,
  input  logic [15:0]   ixIn,
  input  logic [7:0]    accAIn,
  input  logic [7:0]    accBIn,
  input  logic [7:0]    ccrIn,
  input  logic [AW-1:0] spIn,
  input  logic [7:0]    memRdata,
  output logic          memWe,
  output logic          memRe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  output logic [AW-1:0] spOut,
  output logic [15:0]   pcOut,
  output logic [15:0]   iyOut,
  output logic [15:0]   ixOut,
  output logic [7:0]    accAOut,
  output logic [7:0]    accBOut,
  output logic [7:0]    ccrOut
);
  localparam logic [7:0] I_MASK = 8'(1 << CCR_I);
  localparam logic [7:0] X_MASK = 8'(1 << CCR_X);

  logic [15:0]   snapPc, snapIy, snapIx;
  logic [7:0]    snapA, snapB, snapCcr;
  logic          snapXirq;
  logic [AW-1:0] baseSp;
  logic [IDX_W-1:0] slot;
  logic [7:0]    ctxBytes [CTX_BYTES];

  // slot k is the byte at distance k below the entry stack pointer
  assign ctxBytes[0] = snapPc[7:0];
  assign ctxBytes[1] = snapPc[15:8];
  assign ctxBytes[2] = snapIy[7:0];
  assign ctxBytes[3] = snapIy[15:8];
  assign ctxBytes[4] = snapIx[7:0];
  assign ctxBytes[5] = snapIx[15:8];
  assign ctxBytes[6] = snapA;
  assign ctxBytes[7] = snapB;
  assign ctxBytes[8] = snapCcr;

  assign slot     = ctl.popDir ? (LAST_IDX - ctl.idx) : ctl.idx;
  assign memWe    = ctl.doWrite;
  assign memRe    = ctl.doRead;
  assign memWdata = ctl.doWrite ? ctxBytes[slot] : 8'h00;
  assign memAddr  = ctl.doRead  ? (baseSp + AW'(1) + AW'(ctl.idx))
                  : ctl.doWrite ? (baseSp - AW'(ctl.idx)) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapPc <= '0; snapIy <= '0; snapIx <= '0;
      snapA <= '0; snapB <= '0; snapCcr <= '0;
      snapXirq <= 1'b0; baseSp <= '0;
    end else if (ctl.capture) begin
      snapPc <= pcIn; snapIy <= iyIn; snapIx <= ixIn;
      snapA <= accAIn; snapB <= accBIn; snapCcr <= ccrIn;
      snapXirq <= xirqEntry; baseSp <= spIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spOut <= '0; pcOut <= '0; iyOut <= '0; ixOut <= '0;
      accAOut <= '0; accBOut <= '0; ccrOut <= '0;
    end else begin
      if (ctl.doRead) begin
        case (slot)
          4'd0: pcOut[7:0]  <= memRdata;
          4'd1: pcOut[15:8] <= memRdata;
          4'd2: iyOut[7:0]  <= memRdata;
          4'd3: iyOut[15:8] <= memRdata;
          4'd4: ixOut[7:0]  <= memRdata;
          4'd5: ixOut[15:8] <= memRdata;
          4'd6: accAOut     <= memRdata;
          4'd7: accBOut     <= memRdata;
          4'd8: ccrOut      <= memRdata & (~X_MASK | (snapCcr & X_MASK));
          default: ;
        endcase
        if (ctl.finish) spOut <= baseSp + AW'(CTX_BYTES);
      end
      if (ctl.doWrite && ctl.finish) begin
        spOut   <= baseSp - AW'(CTX_BYTES);
        pcOut   <= snapPc;
        iyOut   <= snapIy;
        ixOut   <= snapIx;
        accAOut <= snapA;
        accBOut <= snapB;
        ccrOut  <= snapCcr | I_MASK | (snapXirq ? X_MASK : 8'h00);
      end
    end
  end

  // R2
  push_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) - AW'(1)));
  // R5
  pop_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> (memAddr == $past(memAddr) + AW'(1)));
  // R4
  push_imask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && ctl.finish) |=> ccrOut[CCR_I]);
  // R4
  push_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && ctl.finish) |=> (spOut == $past(memAddr) - AW'(1)));
  // R6
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && ctl.finish) |=> (spOut == $past(memAddr)));
  // R7
  pop_xrule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && ctl.finish) |=> (!ccrOut[CCR_X] || $past(snapCcr[CCR_X])));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memWe && memRe));
endmodule

// File: rtl/ctxStacker.sv
module ctxStacker
  import ctx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPush,
  input  logic          startPop,
  input  logic          xirqEntry,
  input  logic [15:0]   pcIn,
  input  logic [15:0]   iyIn,
  input  logic [15:0]   ixIn,
  input  logic [7:0]    accAIn,
  input  logic [7:0]    accBIn,
  input  logic [7:0]    ccrIn,
  input  logic [AW-1:0] spIn,
  input  logic [7:0]    memRdata,
  output logic          memWe,
  output logic          memRe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  output logic [AW-1:0] spOut,
  output logic [15:0]   pcOut,
  output logic [15:0]   iyOut,
  output logic [15:0]   ixOut,
  output logic [7:0]    accAOut,
  output logic [7:0]    accBOut,
  output logic [7:0]    ccrOut,
  output logic          done
);
  ctlBus_t ctl;

  ctxCtl uCtl (
    .clk(clk), .rstN(rstN), .startPush(startPush), .startPop(startPop),
    .ctl(ctl), .done(done)
  );

  ctxData #(.AW(AW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xirqEntry(xirqEntry),
    .pcIn(pcIn), .iyIn(iyIn), .ixIn(ixIn), .accAIn(accAIn), .accBIn(accBIn),
    .ccrIn(ccrIn), .spIn(spIn), .memRdata(memRdata),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .spOut(spOut), .pcOut(pcOut), .iyOut(iyOut), .ixOut(ixOut),
    .accAOut(accAOut), .accBOut(accBOut), .ccrOut(ccrOut)
  );
endmodule

// File: tb/ctxStacker_test.sv
module ctxStacker_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPush = 1'b0, startPop = 1'b0, xirqEntry = 1'b0;
  logic [15:0] pcIn = '0, iyIn = '0, ixIn = '0, spIn = '0;
  logic [7:0]  accAIn = '0, accBIn = '0, ccrIn = '0;
  logic [7:0]  memRdata;
  logic        memWe, memRe, done;
  logic [15:0] memAddr, spOut, pcOut, iyOut, ixOut;
  logic [7:0]  memWdata, accAOut, accBOut, ccrOut;

  int checks = 0;
  int failures = 0;
  logic [7:0]  mem [256];
  logic [23:0] wq [$];
  logic [15:0] rq [$];

  always #5 clk = ~clk;

  ctxStacker uut (
    .clk(clk), .rstN(rstN), .startPush(startPush), .startPop(startPop),
    .xirqEntry(xirqEntry), .pcIn(pcIn), .iyIn(iyIn), .ixIn(ixIn),
    .accAIn(accAIn), .accBIn(accBIn), .ccrIn(ccrIn), .spIn(spIn),
    .memRdata(memRdata), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .spOut(spOut), .pcOut(pcOut), .iyOut(iyOut),
    .ixOut(ixOut), .accAOut(accAOut), .accBOut(accBOut), .ccrOut(ccrOut),
    .done(done)
  );

  assign memRdata = mem[memAddr[7:0]];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares every memory cycle against the scoreboard queues
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        if (wq.size() == 0) chk("R8", "unexpected write addr", {16'h0, memAddr}, 32'hFFFF_FFFF);
        else chk("R2", "write addr/data", {8'h0, memAddr, memWdata}, {8'h0, wq.pop_front()});
        mem[memAddr[7:0]] = memWdata;
      end
      if (memRe) begin
        if (rq.size() == 0) chk("R8", "unexpected read addr", {16'h0, memAddr}, 32'hFFFF_FFFF);
        else chk("R5", "read addr", {16'h0, memAddr}, {16'h0, rq.pop_front()});
      end
    end
  end

  task automatic waitDone(input string req, input logic strayPop, input logic strayDone);
    int cyc = 1;
    @(negedge clk);
    startPush = 1'b0; startPop = 1'b0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      startPop = (strayPop && cyc == 4);
    end
    startPop = 1'b0;
    chk("R10", {req, " cycles to done"}, cyc, 10);
    if (strayDone) startPush = 1'b1;
  endtask

  task automatic afterDone();
    @(negedge clk);
    startPush = 1'b0;
    chk("R10", "done one cycle", {31'h0, done}, 0);
    @(negedge clk);
    chk("R8", "no memory cycle after done", {30'h0, memWe, memRe}, 0);
    chk("R8", "queues drained", wq.size() + rq.size(), 0);
  endtask

  task automatic doPush(input logic [15:0] sp, pc, iy, ix, input logic [7:0] a, b, ccr,
                        input logic xirq, input logic both, input logic strayPop, input logic strayDone);
    logic [7:0] bytes [9];
    logic [7:0] expCcr;
    bytes = '{pc[7:0], pc[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], a, b, ccr};
    for (int k = 0; k < 9; k++) wq.push_back({sp - 16'(k), bytes[k]});
    spIn = sp; pcIn = pc; iyIn = iy; ixIn = ix; accAIn = a; accBIn = b; ccrIn = ccr;
    xirqEntry = xirq; startPush = 1'b1; startPop = both;
    waitDone("R2", strayPop, strayDone);
    expCcr = ccr | 8'h10 | (xirq ? 8'h40 : 8'h00);
    chk("R4", "push spOut", spOut, sp - 16'd9);
    chk("R4", "push pcOut", pcOut, pc);
    chk("R4", "push iyOut", iyOut, iy);
    chk("R4", "push ixOut", ixOut, ix);
    chk("R4", "push acc", {accAOut, accBOut}, {a, b});
    chk("R4", "push ccrOut", ccrOut, expCcr);
    chk("R3", "stored CCR byte", mem[8'(sp - 16'd8)], ccr);
    afterDone();
  endtask

  task automatic doPop(input logic [15:0] sp, input logic [7:0] liveCcr,
                       input logic [15:0] pc, iy, ix, input logic [7:0] a, b, expCcr);
    for (int j = 1; j <= 9; j++) rq.push_back(sp + 16'(j));
    spIn = sp; ccrIn = liveCcr; pcIn = 16'hDEAD; iyIn = 16'hBEEF; ixIn = 16'hCAFE;
    startPop = 1'b1;
    waitDone("R5", 1'b0, 1'b0);
    chk("R6", "pop spOut", spOut, sp + 16'd9);
    chk("R6", "pop pcOut", pcOut, pc);
    chk("R6", "pop iyOut", iyOut, iy);
    chk("R6", "pop ixOut", ixOut, ix);
    chk("R6", "pop acc", {accAOut, accBOut}, {a, b});
    chk("R7", "pop ccrOut", ccrOut, expCcr);
    afterDone();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "reset strobes", {29'h0, memWe, memRe, done}, 0);
    chk("R1", "reset outputs", {spOut ^ pcOut ^ iyOut ^ ixOut, accAOut | accBOut | ccrOut} , 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "after reset outputs", {spOut, ccrOut, accAOut}, 0);

    // maskable entry, then return
    doPush(16'h00C0, 16'h1234, 16'h5678, 16'h9ABC, 8'hDE, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    doPop(16'h00B7, 8'h10, 16'h1234, 16'h5678, 16'h9ABC, 8'hDE, 8'hF0, 8'h00);

    // non-maskable entry with masks clear, then return
    doPush(16'h0080, 16'hA1B2, 16'hC3D4, 16'hE5F6, 8'h07, 8'h18, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0);
    doPop(16'h0077, 8'h55, 16'hA1B2, 16'hC3D4, 16'hE5F6, 8'h07, 8'h18, 8'h05);

    // stacked X set with live X set: X kept (R7)
    doPush(16'h0060, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0);
    doPop(16'h0057, 8'h50, 16'h1111, 16'h2222, 16'h3333, 8'h44, 8'h55, 8'h40);

    // stack claims X set but live X clear: X stays clear (R7)
    doPush(16'h0040, 16'h0F0E, 16'h0D0C, 16'h0B0A, 8'h09, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    mem[8'h38] = 8'hC3;
    doPop(16'h0037, 8'h10, 16'h0F0E, 16'h0D0C, 16'h0B0A, 8'h09, 8'h08, 8'h83);

    // stray pop mid-push and stray push in done cycle are ignored (R8)
    doPush(16'h00F0, 16'h2468, 16'h1357, 16'hFEDC, 8'hBA, 8'h98, 8'h2A, 1'b0, 1'b0, 1'b1, 1'b1);

    // simultaneous strobes: push wins (R9)
    doPush(16'h0020, 16'h7654, 16'h3210, 16'h89AB, 8'hCD, 8'hEF, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9", "push taken on simultaneous strobes", {16'h0, spOut}, 32'h0017);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule